// File: doc/BRIEF.md
# Dual-Style Parallel Host Register Port

This block is the slave end of an asynchronous parallel microcontroller bus. Through it the host reads and writes a small bank of 8-bit control and status registers inside the chip. One set of pins serves two strobe conventions. In the split-strobe style, separate active-low read and write strobes mark the cycle. In the direction-line style, a single active-low data strobe marks the cycle and a level line gives its direction. A two-bit strap picks the style. Its value is taken while reset is asserted and kept until the next reset. The two remaining strap codes belong to serial host ports, and under them the parallel port stays silent.

Reads are combinational. The addressed register is driven onto the shared data bus for as long as the read strobe is active. Writes are brought into the internal clock domain through synchronizers. The write data is snapshotted while the write strobe is active and committed when the strobe ends. A completion handshake can also be switched on with a control bit. It is an active-low open-drain line that pulls low once the access has been synchronized and timed. It is released the moment the strobe or chip select goes away, so several devices can share one pulled-up wire.

Top module: `hostbus_port`

## Requirements
- R1: With strap 00, a cycle with csN and wrRw both low writes dataBus into the register at addr when wrRw rises. A cycle with csN and rdDs both low returns that register on dataBus.
- R2: With strap 01, rdDs is the data strobe and wrRw is the direction (1 = read, 0 = write). A write commits when the strobe ends, and a read returns the register on dataBus.
- R3: With strap 10 or 11, the port never drives dataBus and never pulls hsN low, whatever the bus pins do.
- R4: The strap is taken while rstN is low. A strap change after reset leaves the bus style unchanged.
- R5: After reset, registers 1 to 15 read 0x00 and register 0 reads the fixed identifier 0xA5. Writes to register 0 are ignored.
- R6: dataBus is high-impedance whenever no read is active.
- R7: The handshake is only produced when bit 0 of register 1 is 1. When that bit is 0, hsN stays released through a whole access.
- R8: hsN is never pulled low while csN is high, in either style.
- R9: Once a strobe is asserted, hsN stays released for at least the first clock edge and is pulled low within eight edges. It is released at once when the strobe rises, even with csN still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset; the strap is taken while low |
| modeStrap | input | 2 | Bus style strap: 00 split strobes, 01 strobe+direction, 1x serial (port idle) |
| csN | input | 1 | Active-low chip select |
| wrRw | input | 1 | Write strobe (active low) or direction line (1 = read) |
| rdDs | input | 1 | Read strobe or data strobe, active low |
| addr | input | 4 | Register address |
| dataBus | inout | 8 | Bidirectional data bus, driven only during reads |
| hsN | inout | 1 | Open-drain completion handshake, active low |

## Verification
The hardest case to reach is a handshake that outlives its access. That would be a pull-down that is still active after the strobe rises while chip select stays low, or after chip select rises while the strobe is still low. The bench reaches it by first turning the handshake on through a register write. It then holds a strobe long enough for the pull-down to appear and releases the strobe and chip select one at a time, sampling hsN right after each edge. A monitor also watches hsN against csN on every cycle in both bus styles.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'b00,
    MODE_DIRSTB = 2'b01,
    MODE_SER_A  = 2'b10,
    MODE_SER_B  = 2'b11
  } busMode_t;

  typedef struct packed {
    logic capture;    // snapshot address/data this cycle
    logic commit;     // write snapshot into the bank
    logic readDrive;  // drive read data onto the bus
  } hbStrobes_t;

  function automatic logic isWriteCyc(busMode_t m, logic cs, logic a, logic b);
    case (m)
      MODE_SPLIT:  return !cs && !a;
      MODE_DIRSTB: return !cs && !b && !a;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic isReadCyc(busMode_t m, logic cs, logic a, logic b);
    case (m)
      MODE_SPLIT:  return !cs && !b;
      MODE_DIRSTB: return !cs && !b && a;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic isAnyCyc(busMode_t m, logic cs, logic a, logic b);
    case (m)
      MODE_SPLIT:  return !cs && (!a || !b);
      MODE_DIRSTB: return !cs && !b;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hostbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HS_DELAY    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeStrap,
  input  logic       csN,
  input  logic       wrRw,
  input  logic       rdDs,
  input  logic       hsEnable,
  output hbStrobes_t strobes,
  output logic       hsPull
);
  localparam int CNT_W = $clog2(HS_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HS_DELAY);

  busMode_t modeQ;
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= busMode_t'(modeStrap);
  end

  // synchronizers for the three bus control pins
  logic [2:0] rawPins, syncPins;
  assign rawPins = {csN, wrRw, rdDs};

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[SYNC_STAGES-2:0], rawPins[g]};
      end
      assign syncPins[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic syncWrite, syncWritePrev, syncAccess, rawAccess;
  assign syncWrite  = isWriteCyc(modeQ, syncPins[2], syncPins[1], syncPins[0]);
  assign syncAccess = isAnyCyc(modeQ, syncPins[2], syncPins[1], syncPins[0]);
  assign rawAccess  = isAnyCyc(modeQ, csN, wrRw, rdDs);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncWritePrev <= 1'b0;
    else       syncWritePrev <= syncWrite;
  end

  always_comb begin
    strobes.capture   = syncWrite;
    strobes.commit    = syncWritePrev && !syncWrite;
    strobes.readDrive = isReadCyc(modeQ, csN, wrRw, rdDs);
  end

  // handshake timer
  logic [CNT_W-1:0] hsCnt;
  logic hsArm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsCnt <= '0;
      hsArm <= 1'b0;
    end else if (!syncAccess) begin
      hsCnt <= '0;
      hsArm <= 1'b0;
    end else begin
      if (hsCnt != CNT_LAST) hsCnt <= hsCnt + 1'b1;
      hsArm <= (hsCnt == CNT_LAST);
    end
  end

  assign hsPull = hsEnable && hsArm && rawAccess;

  a_r4_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeQ));

  a_r3_serial_quiet: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[1] |-> (!strobes.commit && !hsArm && !strobes.readDrive));

  a_r9_arm_not_early: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncAccess) |=> !hsArm);

  a_r9_arm_follows_access: assert property (@(posedge clk) disable iff (!rstN)
    hsArm |-> $past(syncAccess));

endmodule

// File: rtl/hostbus_regs.sv
module hostbus_regs
  import hostbus_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ID_VALUE = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbStrobes_t        strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              hsEnable
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank [DEPTH];
  logic [ADDR_W-1:0] snapAddr;
  logic [DATA_W-1:0] snapData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapAddr <= '0;
      snapData <= '0;
    end else if (strobes.capture) begin
      snapAddr <= addr;
      snapData <= dataIn;
    end
  end

  genvar r;
  generate
    for (r = 0; r < DEPTH; r++) begin : gReg
      if (r == 0) begin : gId
        assign bank[r] = DATA_W'(ID_VALUE);
      end else begin : gRw
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) bank[r] <= '0;
          else if (strobes.commit && snapAddr == ADDR_W'(r)) bank[r] <= snapData;
        end
      end
    end
  endgenerate

  assign rdData   = bank[addr];
  assign hsEnable = bank[1][0];

  a_r1_commit_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && snapAddr != '0) |=> (bank[$past(snapAddr)] == $past(snapData)));

  a_r5_id_fixed: assert property (@(posedge clk) disable iff (!rstN)
    bank[0] == DATA_W'(ID_VALUE));

endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hostbus_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] ID_VALUE    = 8'hA5,
  parameter int         SYNC_STAGES = 2,
  parameter int         HS_DELAY    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeStrap,
  input  logic              csN,
  input  logic              wrRw,
  input  logic              rdDs,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataBus,
  inout  wire               hsN
);
  hbStrobes_t        strobes;
  logic              hsEnable, hsPull;
  logic [DATA_W-1:0] rdData;

  hostbus_ctrl #(.SYNC_STAGES(SYNC_STAGES), .HS_DELAY(HS_DELAY)) uCtrl (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .csN(csN), .wrRw(wrRw),
    .rdDs(rdDs), .hsEnable(hsEnable), .strobes(strobes), .hsPull(hsPull)
  );

  hostbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .dataIn(dataBus),
    .rdData(rdData), .hsEnable(hsEnable)
  );

  assign dataBus = strobes.readDrive ? rdData : {DATA_W{1'bz}};
  assign hsN     = hsPull ? 1'b0 : 1'bz;

  a_r6_drive_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readDrive |-> !csN);

  a_r7_pull_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    hsPull |-> uRegs.bank[1][0]);

endmodule

// File: tb/hostbus_port_test.sv
`timescale 1ns/1ps
module hostbus_port_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] modeStrap = 2'b00;
  logic       csN = 1, wrRw = 1, rdDs = 1;
  logic [3:0] addr = 0;
  logic [7:0] tbData = 0;
  logic       tbDrv = 0;
  logic       dirStyle = 0;
  wire  [7:0] dataBus;
  wire        hsN;
  int total = 0, bad = 0, r8Bad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  assign dataBus = tbDrv ? tbData : 8'hzz;
  pullup puHs (hsN);
  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : gPu
      pullup puD (dataBus[gi]);
    end
  endgenerate

  hostbus_port uut (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .csN(csN), .wrRw(wrRw),
    .rdDs(rdDs), .addr(addr), .dataBus(dataBus), .hsN(hsN)
  );

  // R8 monitor
  always @(negedge clk) if (csN && hsN == 1'b0) r8Bad++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doReset(input logic [1:0] strap, input logic dir);
    modeStrap = strap; dirStyle = dir;
    csN = 1; wrRw = 1; rdDs = 1; tbDrv = 0;
    rstN = 0; waitClk(3);
    rstN = 1; waitClk(2);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    addr = a; tbData = d; tbDrv = 1; #1;
    csN = 0;
    if (dirStyle) begin wrRw = 0; rdDs = 0; end
    else wrRw = 0;
    waitClk(8);
    if (dirStyle) rdDs = 1; else wrRw = 1;
    #1 csN = 1;
    waitClk(5);
    wrRw = 1; tbDrv = 0;
    waitClk(2);
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1;
    csN = 0;
    if (dirStyle) begin wrRw = 1; rdDs = 0; end
    else rdDs = 0;
    #2 d = dataBus;
    waitClk(8);
    rdDs = 1; #1 csN = 1;
    waitClk(4);
  endtask

  task automatic testResetState();
    logic [7:0] v;
    doReset(2'b00, 0);
    check(dataBus == 8'hFF, "R6 idle bus", dataBus, 8'hFF);
    busRead(4'h0, v); check(v == 8'hA5, "R5 id", v, 8'hA5);
    busRead(4'h3, v); check(v == 8'h00, "R5 reset value", v, 8'h00);
    busRead(4'hF, v); check(v == 8'h00, "R5 reset value top", v, 8'h00);
  endtask

  task automatic testSplitStyle();
    logic [7:0] v;
    busWrite(4'h3, 8'h3C); busRead(4'h3, v);
    check(v == 8'h3C, "R1 write/read", v, 8'h3C);
    busWrite(4'hE, 8'hC1); busRead(4'hE, v);
    check(v == 8'hC1, "R1 second reg", v, 8'hC1);
    busRead(4'h3, v);
    check(v == 8'h3C, "R1 no crosstalk", v, 8'h3C);
    busWrite(4'h0, 8'h11); busRead(4'h0, v);
    check(v == 8'hA5, "R5 id write ignored", v, 8'hA5);
    check(dataBus == 8'hFF, "R6 released after read", dataBus, 8'hFF);
  endtask

  task automatic testHsDisabled();
    addr = 4'h3; #1 csN = 0; rdDs = 0;
    waitClk(8);
    check(hsN == 1'b1, "R7 disabled handshake", hsN, 1);
    rdDs = 1; #1 csN = 1; waitClk(4);
  endtask

  task automatic testHsTiming();
    busWrite(4'h1, 8'h01);
    addr = 4'h3; #1 csN = 0;
    if (dirStyle) begin wrRw = 1; rdDs = 0; end else rdDs = 0;
    waitClk(1);
    check(hsN == 1'b1, "R9 not early", hsN, 1);
    waitClk(7);
    check(hsN == 1'b0, "R9 asserted", hsN, 0);
    rdDs = 1; #1;
    check(hsN == 1'b1, "R9 released on strobe", hsN, 1);
    waitClk(1);
    check(hsN == 1'b1, "R9 stays released", hsN, 1);
    csN = 1; waitClk(4);
    // chip select rises while strobe still low
    #1 csN = 0; rdDs = 0;
    waitClk(8);
    check(hsN == 1'b0, "R9 asserted again", hsN, 0);
    csN = 1; #1;
    check(hsN == 1'b1, "R8 released on cs", hsN, 1);
    rdDs = 1; waitClk(4);
  endtask

  task automatic testStrapChange();
    logic [7:0] v;
    doReset(2'b00, 0);
    modeStrap = 2'b01;
    busWrite(4'h5, 8'h77); busRead(4'h5, v);
    check(v == 8'h77, "R4 strap change ignored", v, 8'h77);
  endtask

  task automatic testDirStyle();
    logic [7:0] v;
    doReset(2'b01, 1);
    busRead(4'h0, v); check(v == 8'hA5, "R2 id read", v, 8'hA5);
    busWrite(4'h7, 8'hC3); busRead(4'h7, v);
    check(v == 8'hC3, "R2 write/read", v, 8'hC3);
    addr = 4'h7; #1 csN = 0; wrRw = 0; #2;
    check(dataBus == 8'hFF, "R6 no drive with write dir", dataBus, 8'hFF);
    csN = 1; wrRw = 1; waitClk(4);
    testHsTiming();
  endtask

  task automatic testSerial(input logic [1:0] strap);
    doReset(strap, 0);
    addr = 4'h0; #1 csN = 0; rdDs = 0; #2;
    check(dataBus == 8'hFF, "R3 bus idle", dataBus, 8'hFF);
    waitClk(8);
    check(hsN == 1'b1, "R3 handshake idle", hsN, 1);
    wrRw = 0; #2;
    check(dataBus == 8'hFF, "R3 bus idle both", dataBus, 8'hFF);
    rdDs = 1; wrRw = 1; #1 csN = 1; waitClk(3);
  endtask

  initial begin
    testResetState();
    testSplitStyle();
    testHsDisabled();
    testHsTiming();
    testStrapChange();
    testDirStyle();
    testSerial(2'b10);
    testSerial(2'b11);
    check(r8Bad == 0, "R8 hs low with cs high", r8Bad, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule